// File: doc/BRIEF.md
# Backup Power Shutdown and Wake Controller

This always-on controller runs from a slow clock. It owns an active-low output, `shdn_n_o`, that enables the chip's external main voltage regulator. Firmware asks for the regulator to be turned off by writing 1 to a one-bit control field through a write strobe. The controller then passes through a short entry state into backup mode, and it holds `shdn_n_o` low for as long as it stays there.

A wake event ends backup mode. The event can come from the dedicated active-low force-wake pin or from any enabled general wake line. When it arrives, the controller raises `shdn_n_o` at once. It then counts a configurable settle interval in slow-clock cycles before it reports that the supply is ready and returns to the active state.

All wake inputs pass through two-flop synchronisers. The synchronised force-wake also produces a wake flag for the core's lighter sleep modes, so the pin works in every low-power mode. A 2-bit mode output exposes the state.

Top module: `bkup_pwr_ctl`

## Requirements
- R1: After reset, `mode_o` is 00 (active), `shdn_n_o` is 1, `supply_ready_o` is 1 and `regoff_bit_o` is 0.
- R2: In mode 00 with no wake pending, a strobe carrying data 1 sets `regoff_bit_o` at that edge. Mode 01 (entering) follows at the next edge and mode 10 (backup) at the edge after that. The bit clears by itself on the edge that enters mode 10.
- R3: A strobe carrying data 0 changes nothing. A strobe outside mode 00 is ignored.
- R4: `shdn_n_o` is 0 exactly while the mode is 01 or 10, and `supply_ready_o` is 0 whenever the mode is not 00.
- R5: In mode 10, driving `force_wake_n_i` low is seen after two synchroniser edges. The third edge moves the controller to mode 11 (waking) with `shdn_n_o` back at 1.
- R6: A general wake line wakes the controller from mode 10 only while its enable bit is 1. A line whose enable bit is 0 keeps the controller in mode 10.
- R7: Mode 11 lasts exactly S slow-clock cycles, where S is `settle_cycles_i`; a value of 0 selects 64. The controller then returns to mode 00 with `supply_ready_o` at 1.
- R8: A data-1 strobe that arrives while a synchronised wake event is pending is ignored. The control bit stays 0 and the mode stays 00.
- R9: `sleep_wake_o` is 1 exactly while `sleep_i` is 1 and a synchronised force-wake or enabled wake line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_regoff_i | input | 1 | Regulator-off data bit carried by the strobe |
| settle_cycles_i | input | CNT_W | Settle interval in cycles; 0 selects 64 |
| force_wake_n_i | input | 1 | Asynchronous active-low force-wake pin |
| wake_src_i | input | N_WAKE | Asynchronous general wake lines, active high |
| wake_en_i | input | N_WAKE | Enable bit for each general wake line |
| sleep_i | input | 1 | Core is in a non-backup low-power mode |
| shdn_n_o | output | 1 | Regulator enable, low in backup |
| supply_ready_o | output | 1 | Supply settled, controller active |
| mode_o | output | 2 | 00 active, 01 entering, 10 backup, 11 waking |
| regoff_bit_o | output | 1 | Readback of the self-clearing control bit |
| sleep_wake_o | output | 1 | Wake flag for the lighter sleep modes |

## Verification
Two things can fall in the same cycle: a firmware request to turn the regulator off, and a wake event that has just come out of the synchroniser. The bench pulls the force-wake pin low and then times the strobe so that the edge which samples the strobe is the first edge at which the synchronised wake is high. The request must be dropped: the control bit must stay 0, the mode must remain 00 and `shdn_n_o` must never fall. A second case puts a disabled wake line active in backup and then enables it. The controller must leave backup on the very next edge.

// File: rtl/bkup_pwr_pkg.sv
package bkup_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_ENTER  = 2'b01,
    MODE_BACKUP = 2'b10,
    MODE_WAKING = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/bkup_rst_sync.sv
module bkup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bkup_wake_in.sv
module bkup_wake_in #(
  parameter int N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_wake_n,
  input  logic [N_WAKE-1:0] wake_src,
  input  logic [N_WAKE-1:0] wake_en,
  output logic              wake_any
);
  logic              fw_s1_n, fw_s2_n;
  logic [N_WAKE-1:0] src_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_s1_n <= 1'b1;
      fw_s2_n <= 1'b1;
    end else begin
      fw_s1_n <= force_wake_n;
      fw_s2_n <= fw_s1_n;
    end
  end

  for (genvar g = 0; g < N_WAKE; g++) begin : g_src
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= wake_src[g];
        s2_q <= s1_q;
      end
    end
    assign src_s2[g] = s2_q;
  end

  assign wake_any = !fw_s2_n || |(src_s2 & wake_en);

  // R5: a synchronised force-wake follows the pin with two stages of delay
  a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fw_s2_n) |-> $past(fw_s1_n) == 1'b0);
endmodule

// File: rtl/bkup_settle_timer.sv
module bkup_settle_timer #(
  parameter int CNT_W      = 8,
  parameter int DEF_SETTLE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] cfg,
  output logic             done
);
  localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(DEF_SETTLE);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit, last;

  assign limit = (cfg == '0) ? DEF_VAL : cfg;
  assign last  = limit - CNT_W'(1);
  assign done  = run && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (start)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start || run) cnt_q <= cnt_d;
  end

  // R7: the count never passes the selected settle length
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < limit);
endmodule

// File: rtl/bkup_pwr_fsm.sv
module bkup_pwr_fsm
  import bkup_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic      wdata,
  input  logic      wake_any,
  input  logic      timer_done,
  output logic      timer_start,
  output logic      timer_run,
  output logic      shdn_n,
  output logic      ready,
  output logic      regoff,
  output pwr_mode_e mode
);
  pwr_mode_e state_q, state_d;
  logic      shdn_n_q, ready_q, regoff_q;
  logic      regoff_d, accept;

  assign accept = (state_q == MODE_ACTIVE) && wr && wdata && !wake_any;

  always_comb begin
    state_d     = state_q;
    timer_start = 1'b0;
    timer_run   = 1'b0;
    unique case (state_q)
      MODE_ACTIVE: if (regoff_q) state_d = MODE_ENTER;
      MODE_ENTER:  state_d = MODE_BACKUP;
      MODE_BACKUP: if (wake_any) begin
                     state_d     = MODE_WAKING;
                     timer_start = 1'b1;
                   end
      MODE_WAKING: begin
                     timer_run = 1'b1;
                     if (timer_done) state_d = MODE_ACTIVE;
                   end
      default:     state_d = MODE_ACTIVE;
    endcase
  end

  always_comb begin
    regoff_d = regoff_q;
    if (accept)                          regoff_d = 1'b1;
    else if (state_d == MODE_BACKUP)     regoff_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MODE_ACTIVE;
      shdn_n_q <= 1'b1;
      ready_q  <= 1'b1;
      regoff_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      shdn_n_q <= !(state_d == MODE_ENTER || state_d == MODE_BACKUP);
      ready_q  <= (state_d == MODE_ACTIVE);
      regoff_q <= regoff_d;
    end
  end

  assign shdn_n = shdn_n_q;
  assign ready  = ready_q;
  assign regoff = regoff_q;
  assign mode   = state_q;

  // R4: regulator disabled while in backup
  a_r4_shdn_low_backup: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_BACKUP) |-> !shdn_n_q);
  // R4: supply ready reported only when active
  a_r4_ready_active: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> state_q == MODE_ACTIVE);
  // R2: the control bit is clear once backup is reached
  a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_BACKUP) |-> !regoff_q);
  // R5: a wake in backup re-enables the regulator at the next edge
  a_r5_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_BACKUP && wake_any) |=> (state_q == MODE_WAKING && shdn_n_q));
  // R8: a request meeting a pending wake is dropped
  a_r8_drop_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_ACTIVE && wr && wdata && wake_any && !regoff_q) |=> !regoff_q);
endmodule

// File: rtl/bkup_pwr_ctl.sv
module bkup_pwr_ctl
  import bkup_pwr_pkg::*;
#(
  parameter int N_WAKE     = 4,
  parameter int CNT_W      = 8,
  parameter int DEF_SETTLE = 64
) (
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              ctl_wr_i,
  input  logic              ctl_regoff_i,
  input  logic [CNT_W-1:0]  settle_cycles_i,
  input  logic              force_wake_n_i,
  input  logic [N_WAKE-1:0] wake_src_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  input  logic              sleep_i,
  output logic              shdn_n_o,
  output logic              supply_ready_o,
  output logic [1:0]        mode_o,
  output logic              regoff_bit_o,
  output logic              sleep_wake_o
);
  logic      rst_n_s, wake_any, t_start, t_run, t_done;
  pwr_mode_e mode;

  bkup_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_slow), .rst_n_async(rst_n), .rst_n_sync(rst_n_s));

  bkup_wake_in #(.N_WAKE(N_WAKE)) u_wake (
    .clk(clk_slow), .rst_n(rst_n_s), .force_wake_n(force_wake_n_i),
    .wake_src(wake_src_i), .wake_en(wake_en_i), .wake_any(wake_any));

  bkup_settle_timer #(.CNT_W(CNT_W), .DEF_SETTLE(DEF_SETTLE)) u_timer (
    .clk(clk_slow), .rst_n(rst_n_s), .start(t_start), .run(t_run),
    .cfg(settle_cycles_i), .done(t_done));

  bkup_pwr_fsm u_fsm (
    .clk(clk_slow), .rst_n(rst_n_s), .wr(ctl_wr_i), .wdata(ctl_regoff_i),
    .wake_any(wake_any), .timer_done(t_done), .timer_start(t_start),
    .timer_run(t_run), .shdn_n(shdn_n_o), .ready(supply_ready_o),
    .regoff(regoff_bit_o), .mode(mode));

  assign mode_o       = mode;
  assign sleep_wake_o = sleep_i && wake_any;
endmodule

// File: tb/bkup_pwr_ctl_tb_top.sv
module bkup_pwr_ctl_tb_top;
  localparam int NW = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr, wdata, fw_n, sleep;
  logic [CW-1:0] settle;
  logic [NW-1:0] src, en;
  logic          shdn_n, ready, regoff, swake;
  logic [1:0]    mode;
  int            n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bkup_pwr_ctl #(.N_WAKE(NW), .CNT_W(CW), .DEF_SETTLE(64)) dut_i (
    .clk_slow(clk), .rst_n(rst_n), .ctl_wr_i(wr), .ctl_regoff_i(wdata),
    .settle_cycles_i(settle), .force_wake_n_i(fw_n), .wake_src_i(src),
    .wake_en_i(en), .sleep_i(sleep), .shdn_n_o(shdn_n),
    .supply_ready_o(ready), .mode_o(mode), .regoff_bit_o(regoff),
    .sleep_wake_o(swake));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic d);
    wr = 1'b1; wdata = d;
    step(1);
    wr = 1'b0; wdata = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 shdn_n", shdn_n, 1);
    chk("R1 ready", ready, 1);
    chk("R1 regoff", regoff, 0);
  endtask

  task automatic t_enter;
    write(1'b1);
    chk("R2 bit set", regoff, 1);
    chk("R2 still active", mode, 0);
    step(1);
    chk("R2 entering", mode, 1);
    chk("R4 shdn low entering", shdn_n, 0);
    chk("R4 ready low", ready, 0);
    step(1);
    chk("R2 backup", mode, 2);
    chk("R2 self clear", regoff, 0);
    chk("R4 shdn low backup", shdn_n, 0);
  endtask

  task automatic t_force_wake(int s);
    int eff;
    eff = (s == 0) ? 64 : s;
    settle = CW'(s);
    fw_n = 1'b0;
    step(2);
    chk("R5 not yet", mode, 2);
    chk("R5 shdn still low", shdn_n, 0);
    step(1);
    chk("R5 waking", mode, 3);
    chk("R5 shdn high", shdn_n, 1);
    fw_n = 1'b1;
    step(eff - 1);
    chk("R7 still waking", mode, 3);
    chk("R7 not ready", ready, 0);
    step(1);
    chk("R7 active", mode, 0);
    chk("R7 ready", ready, 1);
    step(3);
  endtask

  task automatic t_ignored_writes;
    write(1'b0);
    step(2);
    chk("R3 data0 bit", regoff, 0);
    chk("R3 data0 mode", mode, 0);
    t_enter();
    write(1'b1);
    step(2);
    chk("R3 write in backup bit", regoff, 0);
    chk("R3 write in backup mode", mode, 2);
  endtask

  task automatic t_src_wake;
    src = 4'b0100; en = 4'b1011;
    step(5);
    chk("R6 disabled line", mode, 2);
    en = 4'b1111;
    step(1);
    chk("R6 enabled line", mode, 3);
    src = '0; en = '0;
    settle = CW'(2);
    step(5);
    chk("R6 back active", mode, 0);
  endtask

  task automatic t_race;
    fw_n = 1'b0;
    step(2);
    write(1'b1);
    chk("R8 bit dropped", regoff, 0);
    step(1);
    chk("R8 mode", mode, 0);
    chk("R8 shdn", shdn_n, 1);
    fw_n = 1'b1;
    step(3);
  endtask

  task automatic t_sleep;
    sleep = 1'b1;
    fw_n  = 1'b0;
    step(1);
    chk("R9 before sync", swake, 0);
    step(1);
    chk("R9 sleep wake", swake, 1);
    sleep = 1'b0;
    #1 chk("R9 not sleeping", swake, 0);
    fw_n = 1'b1;
    sleep = 1'b1;
    step(2);
    chk("R9 released", swake, 0);
    sleep = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; wdata = 1'b0; fw_n = 1'b1; sleep = 1'b0;
    src = '0; en = '0; settle = CW'(5);
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_enter();
    t_force_wake(5);
    t_enter();
    t_force_wake(1);
    t_ignored_writes();
    t_force_wake(0);
    t_enter();
    t_src_wake();
    t_race();
    t_sleep();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule